// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Pin Sequencer

This block drives the chip select, serial clock and serial data lines of a three-wire serial EEPROM. It does the slow pin work that software would otherwise do by hand. A host issues one primitive at a time over a small command port: it asserts `cmd_valid` with an operation code, a data word and a bit count. The block then plays the matching pin choreography and pulses `done` when it has finished. Each step of a choreography changes one or more pins and then holds them for a fixed dwell of `PHASE_CYC` system clock cycles. That dwell stands in for the tens-of-microseconds settle time the memory needs.

There are five primitives. Setup prepares the memory for a command. Standby returns it to a quiet selected state between commands. Cleanup ends a command. Shift-out sends up to sixteen bits on the data-in line. Shift-in clocks up to sixteen bits back from the data-out line into a result register. Opcode framing, addressing and checksums are left to the host, which builds them from these primitives.

Top module: `eeprom3w_seq`

## Requirements
- R1: After reset, `ee_cs`, `ee_sk`, `ee_di`, `busy` and `done` are all 0, and `rx_data` is 0.
- R2: A command is accepted on a clock edge where `busy` is 0 and `cmd_valid` is 1. From that edge on, the pins walk through the steps of the command. Each step's pin values appear right after the edge that starts the step and are held for exactly `PHASE_CYC` cycles.
- R3: Setup (`cmd_op`=0) takes two steps: first SK and DI go low, then CS goes high.
- R4: Standby (`cmd_op`=1) takes four steps: CS and SK low, then SK high, then CS high, then SK low.
- R5: Cleanup (`cmd_op`=2) takes three steps: CS and DI low, then SK high, then SK low.
- R6: Shift-out (`cmd_op`=3) sends bits `cmd_len-1` down to 0 of `cmd_data`, most significant first. For each bit there are three steps: DI takes the bit, then SK goes high, then SK goes low. A final step drives DI low. CS is never changed.
- R7: Shift-in (`cmd_op`=4) clears `rx_data`. For each of `cmd_len` bits it raises SK for one step and lowers it for one step. It samples `ee_do` in the last cycle of each high step and shifts the sample into bit 0 of `rx_data`. The first bit received therefore ends up in bit `cmd_len-1`. CS and DI are not changed.
- R8: `busy` is 1 from the cycle after the accepting edge until the last step has elapsed. In the first cycle in which `busy` is 0 again, `done` is 1 for exactly that one cycle.
- R9: A `cmd_valid` that arrives while `busy` is 1 is ignored, and the running sequence is not disturbed.
- R10: An operation code of 5, 6 or 7 is ignored, with no change on any pin and no `busy`. The same holds for a shift command whose `cmd_len` is 0 or greater than 16.
- R11: `ee_sk` is low whenever the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command request, taken when the block is idle |
| cmd_op | input | 3 | Operation: 0 setup, 1 standby, 2 cleanup, 3 shift-out, 4 shift-in |
| cmd_data | input | 16 | Word to send for shift-out |
| cmd_len | input | 5 | Bit count for shift commands, 1 to 16 |
| busy | output | 1 | A sequence is running |
| done | output | 1 | One-cycle pulse when a sequence ends |
| rx_data | output | 16 | Bits collected by the last shift-in, right-aligned |
| ee_cs | output | 1 | Memory chip select |
| ee_sk | output | 1 | Memory serial clock |
| ee_di | output | 1 | Serial data toward the memory |
| ee_do | input | 1 | Serial data from the memory |

## Verification
All pins and `busy` are registered. The first step of an accepted command is visible one cycle after the accepting edge, and every later step begins exactly `PHASE_CYC` cycles after the one before it. `done` rises one cycle after the final step has run its full dwell. The bench expands each command into a list of what every single cycle must show: the pins, `busy` and `done`. It pushes that list into the queue just after the accepting edge, and the monitor pops one entry at each falling edge. Every result is therefore compared in the exact cycle it is due. `rx_data` is compared once, after the `done` entry of a shift-in has been consumed.

// File: rtl/eeprom3w_pkg.sv
package eeprom3w_pkg;

    // Host operation codes
    localparam logic [2:0] OP_SETUP   = 3'd0;
    localparam logic [2:0] OP_STANDBY = 3'd1;
    localparam logic [2:0] OP_CLEANUP = 3'd2;
    localparam logic [2:0] OP_SHOUT   = 3'd3;
    localparam logic [2:0] OP_SHIN    = 3'd4;

    // Every pin step of every primitive; each is held for one phase dwell
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SU_LOW,
        ST_SU_CS,
        ST_SB_DESEL,
        ST_SB_SKH,
        ST_SB_SEL,
        ST_SB_SKL,
        ST_CL_DESEL,
        ST_CL_SKH,
        ST_CL_SKL,
        ST_TX_DATA,
        ST_TX_SKH,
        ST_TX_SKL,
        ST_TX_END,
        ST_RX_SKH,
        ST_RX_SKL
    } step_e;

    typedef struct packed {
        logic cs;
        logic sk;
        logic di;
    } pins_t;

    // Pin values in force once step s has been entered
    function automatic pins_t step_pins(step_e s, pins_t cur, logic bit_v);
        pins_t p;
        p = cur;
        case (s)
            ST_SU_LOW:   begin p.sk = 1'b0; p.di = 1'b0; end
            ST_SU_CS:    p.cs = 1'b1;
            ST_SB_DESEL: begin p.cs = 1'b0; p.sk = 1'b0; end
            ST_SB_SKH:   p.sk = 1'b1;
            ST_SB_SEL:   p.cs = 1'b1;
            ST_SB_SKL:   p.sk = 1'b0;
            ST_CL_DESEL: begin p.cs = 1'b0; p.di = 1'b0; end
            ST_CL_SKH:   p.sk = 1'b1;
            ST_CL_SKL:   p.sk = 1'b0;
            ST_TX_DATA:  p.di = bit_v;
            ST_TX_SKH:   p.sk = 1'b1;
            ST_TX_SKL:   p.sk = 1'b0;
            ST_TX_END:   p.di = 1'b0;
            ST_RX_SKH:   p.sk = 1'b1;
            ST_RX_SKL:   p.sk = 1'b0;
            default:     p = cur;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/eeprom3w_phase_timer.sv
module eeprom3w_phase_timer #(
    parameter int PHASE_CYC = 2500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic expire
);
    localparam int TW = (PHASE_CYC > 1) ? $clog2(PHASE_CYC) : 1;
    localparam logic [TW-1:0] RELOAD = TW'(PHASE_CYC - 1);

    logic [TW-1:0] cnt_d, cnt_q;

    // Reload on step entry, then count down to zero and rest there
    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = RELOAD;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expire = (cnt_q == '0);

    // R2
    reload_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt_q == RELOAD));

endmodule

// File: rtl/eeprom3w_shifter.sv
module eeprom3w_shifter #(
    parameter int DATA_W = 16,
    localparam int LEN_W = $clog2(DATA_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              rx_clr,
    input  logic [DATA_W-1:0] tx_word,
    input  logic [LEN_W-1:0]  len,
    input  logic              adv_tx,
    input  logic              dec_rem,
    input  logic              smp_rx,
    input  logic              ser_in,
    output logic              first_bit,
    output logic              next_bit,
    output logic              last,
    output logic [DATA_W-1:0] rx_word
);
    typedef struct packed {
        logic [DATA_W-1:0] tx;
        logic [DATA_W-1:0] rx;
        logic [LEN_W-1:0]  rem;
    } shf_t;

    shf_t s_d, s_q;
    logic [LEN_W-1:0]  align_sh;
    logic [DATA_W-1:0] aligned;

    // Left-justify the low `len` bits so the outgoing bit is always the MSB
    always_comb begin
        align_sh  = LEN_W'(DATA_W) - len;
        aligned   = tx_word << align_sh;
        first_bit = aligned[DATA_W-1];
    end

    always_comb begin
        s_d = s_q;
        if (load) begin
            s_d.tx  = aligned;
            s_d.rem = len;
            if (rx_clr) s_d.rx = '0;
        end else begin
            if (adv_tx)  s_d.tx  = {s_q.tx[DATA_W-2:0], 1'b0};
            if (dec_rem) s_d.rem = s_q.rem - 1'b1;
            if (smp_rx)  s_d.rx  = {s_q.rx[DATA_W-2:0], ser_in};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign next_bit = s_q.tx[DATA_W-2];
    assign last     = (s_q.rem == LEN_W'(1));
    assign rx_word  = s_q.rx;

    // R7
    rx_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_rx && !load) |=> (s_q.rx[0] == $past(ser_in)));

    // R6
    rem_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.rem <= LEN_W'(DATA_W));

endmodule

// File: rtl/eeprom3w_step_fsm.sv
module eeprom3w_step_fsm
    import eeprom3w_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int PHASE_CYC = 2500,
    localparam int LEN_W    = $clog2(DATA_W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [2:0]       cmd_op,
    input  logic [LEN_W-1:0] cmd_len,
    input  logic             expire,
    input  logic             first_bit,
    input  logic             next_bit,
    input  logic             last,
    output logic             tmr_load,
    output logic             sh_load,
    output logic             sh_rx_clr,
    output logic             sh_adv_tx,
    output logic             sh_dec_rem,
    output logic             sh_smp_rx,
    output logic             busy,
    output logic             done,
    output pins_t            pins
);
    typedef struct packed {
        step_e step;
        pins_t pins;
        logic  done;
    } seq_t;

    seq_t  q, n;
    step_e tgt;
    logic  bit_v;
    logic  go;
    logic  len_ok;
    logic  cmd_ok;
    step_e first_step;

    // Legality of a request and the first step of its choreography
    always_comb begin
        len_ok = (cmd_len != '0) && (cmd_len <= LEN_W'(DATA_W));
        cmd_ok = 1'b0;
        first_step = ST_IDLE;
        case (cmd_op)
            OP_SETUP:   begin cmd_ok = 1'b1;   first_step = ST_SU_LOW;   end
            OP_STANDBY: begin cmd_ok = 1'b1;   first_step = ST_SB_DESEL; end
            OP_CLEANUP: begin cmd_ok = 1'b1;   first_step = ST_CL_DESEL; end
            OP_SHOUT:   begin cmd_ok = len_ok; first_step = ST_TX_DATA;  end
            OP_SHIN:    begin cmd_ok = len_ok; first_step = ST_RX_SKH;   end
            default:    begin cmd_ok = 1'b0;   first_step = ST_IDLE;     end
        endcase
    end

    always_comb begin
        n          = q;
        n.done     = 1'b0;
        tgt        = q.step;
        bit_v      = 1'b0;
        go         = 1'b0;
        tmr_load   = 1'b0;
        sh_load    = 1'b0;
        sh_rx_clr  = 1'b0;
        sh_adv_tx  = 1'b0;
        sh_dec_rem = 1'b0;
        sh_smp_rx  = 1'b0;

        if (q.step == ST_IDLE) begin
            if (cmd_valid && cmd_ok) begin
                go        = 1'b1;
                tgt       = first_step;
                bit_v     = first_bit;
                sh_load   = 1'b1;
                sh_rx_clr = (cmd_op == OP_SHIN);
            end
        end else if (expire) begin
            go = 1'b1;
            case (q.step)
                ST_SU_LOW:   tgt = ST_SU_CS;
                ST_SU_CS:    tgt = ST_IDLE;
                ST_SB_DESEL: tgt = ST_SB_SKH;
                ST_SB_SKH:   tgt = ST_SB_SEL;
                ST_SB_SEL:   tgt = ST_SB_SKL;
                ST_SB_SKL:   tgt = ST_IDLE;
                ST_CL_DESEL: tgt = ST_CL_SKH;
                ST_CL_SKH:   tgt = ST_CL_SKL;
                ST_CL_SKL:   tgt = ST_IDLE;
                ST_TX_DATA:  tgt = ST_TX_SKH;
                ST_TX_SKH:   tgt = ST_TX_SKL;
                ST_TX_SKL: begin
                    sh_adv_tx  = 1'b1;
                    sh_dec_rem = 1'b1;
                    if (last) begin
                        tgt = ST_TX_END;
                    end else begin
                        tgt   = ST_TX_DATA;
                        bit_v = next_bit;
                    end
                end
                ST_TX_END:   tgt = ST_IDLE;
                ST_RX_SKH: begin
                    sh_smp_rx = 1'b1;
                    tgt       = ST_RX_SKL;
                end
                ST_RX_SKL: begin
                    sh_dec_rem = 1'b1;
                    tgt        = last ? ST_IDLE : ST_RX_SKH;
                end
                default:     tgt = ST_IDLE;
            endcase
        end

        if (go) begin
            n.step = tgt;
            if (tgt == ST_IDLE) begin
                n.done = 1'b1;
            end else begin
                n.pins   = step_pins(tgt, q.pins, bit_v);
                tmr_load = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{step: ST_IDLE, pins: '0, done: 1'b0};
        else        q <= n;
    end

    assign busy = (q.step != ST_IDLE);
    assign done = q.done;
    assign pins = q.pins;

    // Dwell counter used only by the timing check below
    localparam int DWELL_LAST = PHASE_CYC - 1;
    int unsigned dwell_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                               dwell_q <= 0;
        else if (n.step != q.step)                dwell_q <= 0;
        else if (dwell_q < 32'(PHASE_CYC))        dwell_q <= dwell_q + 1;
    end

    // R2
    dwell_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.step != ST_IDLE && dwell_q != 32'(DWELL_LAST)) |=> (q.step == $past(q.step)));

    // R2
    dwell_leave_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.step != ST_IDLE && dwell_q == 32'(DWELL_LAST)) |=> (q.step != $past(q.step)));

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |=> !q.done);

    // R8
    done_on_finish_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    // R11
    idle_sk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !q.pins.sk);

    // R3
    setup_final_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.step == ST_SU_CS && expire) |=> (q.pins.cs && !q.pins.sk && !q.pins.di));

    // R6
    tx_di_parked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.step == ST_TX_END && expire) |=> !q.pins.di);

    // R10
    bad_op_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cmd_valid && cmd_op > OP_SHIN) |=> (!busy && $stable(q.pins)));

endmodule

// File: rtl/eeprom3w_seq.sv
module eeprom3w_seq
    import eeprom3w_pkg::*;
#(
    parameter int PHASE_CYC = 2500,
    parameter int DATA_W    = 16,
    localparam int LEN_W    = $clog2(DATA_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [DATA_W-1:0] cmd_data,
    input  logic [LEN_W-1:0]  cmd_len,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rx_data,
    output logic              ee_cs,
    output logic              ee_sk,
    output logic              ee_di,
    input  logic              ee_do
);
    logic  expire, tmr_load;
    logic  sh_load, sh_rx_clr, sh_adv_tx, sh_dec_rem, sh_smp_rx;
    logic  first_bit, next_bit, last;
    pins_t pins;

    eeprom3w_phase_timer #(.PHASE_CYC(PHASE_CYC)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (tmr_load),
        .expire (expire)
    );

    eeprom3w_shifter #(.DATA_W(DATA_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (sh_load),
        .rx_clr    (sh_rx_clr),
        .tx_word   (cmd_data),
        .len       (cmd_len),
        .adv_tx    (sh_adv_tx),
        .dec_rem   (sh_dec_rem),
        .smp_rx    (sh_smp_rx),
        .ser_in    (ee_do),
        .first_bit (first_bit),
        .next_bit  (next_bit),
        .last      (last),
        .rx_word   (rx_data)
    );

    eeprom3w_step_fsm #(.DATA_W(DATA_W), .PHASE_CYC(PHASE_CYC)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_valid  (cmd_valid),
        .cmd_op     (cmd_op),
        .cmd_len    (cmd_len),
        .expire     (expire),
        .first_bit  (first_bit),
        .next_bit   (next_bit),
        .last       (last),
        .tmr_load   (tmr_load),
        .sh_load    (sh_load),
        .sh_rx_clr  (sh_rx_clr),
        .sh_adv_tx  (sh_adv_tx),
        .sh_dec_rem (sh_dec_rem),
        .sh_smp_rx  (sh_smp_rx),
        .busy       (busy),
        .done       (done),
        .pins       (pins)
    );

    assign ee_cs = pins.cs;
    assign ee_sk = pins.sk;
    assign ee_di = pins.di;

    // R9
    busy_shields_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cmd_valid) |-> !sh_load);

endmodule

// File: tb/tb_eeprom3w_seq.sv
module tb_eeprom3w_seq;
    localparam int CLK_PERIOD = 10;
    localparam int PHASE      = 3;
    localparam int DW         = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic [2:0]    cmd_op = '0;
    logic [DW-1:0] cmd_data = '0;
    logic [4:0]    cmd_len = '0;
    logic          busy, done, ee_cs, ee_sk, ee_di;
    logic          ee_do = 1'b0;
    logic [DW-1:0] rx_data;

    eeprom3w_seq #(.PHASE_CYC(PHASE), .DATA_W(DW)) dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_data(cmd_data), .cmd_len(cmd_len), .busy(busy), .done(done),
        .rx_data(rx_data), .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di), .ee_do(ee_do)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct {
        logic [4:0] v;   // {cs, sk, di, busy, done}
        string      tag;
    } exp_t;

    exp_t  sb_q[$];
    int    n_cmp = 0;
    int    n_bad = 0;
    logic  m_cs = 1'b0, m_sk = 1'b0, m_di = 1'b0;
    logic [DW-1:0] rx_src = '0;
    int    rx_idx = 0;
    logic  rx_mode = 1'b0;
    bit    finished = 1'b0;

    // Memory stub: presents the next bit when the clock rises
    always @(posedge ee_sk) begin
        if (rx_mode && rx_idx >= 0) begin
            ee_do  <= rx_src[rx_idx];
            rx_idx <= rx_idx - 1;
        end
    end

    // Monitor: one expected entry per cycle, compared at the falling edge
    always @(negedge clk) begin
        if (rst_n && sb_q.size() > 0) begin
            exp_t e;
            logic [4:0] got;
            e   = sb_q.pop_front();
            got = {ee_cs, ee_sk, ee_di, busy, done};
            n_cmp++;
            if (got !== e.v) begin
                n_bad++;
                $display("FAIL %s: {cs,sk,di,busy,done} got %b expected %b at %0t",
                         e.tag, got, e.v, $time);
            end
        end
    end

    task automatic push_step(input logic cs, input logic sk, input logic di, input string tag);
        m_cs = cs; m_sk = sk; m_di = di;
        for (int i = 0; i < PHASE; i++) sb_q.push_back('{v: {m_cs, m_sk, m_di, 2'b10}, tag: tag});
    endtask

    task automatic push_finish(input string tag);
        sb_q.push_back('{v: {m_cs, m_sk, m_di, 2'b01}, tag: tag});
        sb_q.push_back('{v: {m_cs, m_sk, m_di, 2'b00}, tag: tag});
    endtask

    task automatic push_idle(input int n, input string tag);
        for (int i = 0; i < n; i++) sb_q.push_back('{v: {m_cs, m_sk, m_di, 2'b00}, tag: tag});
    endtask

    // Driver: present a request, and return right after the accepting edge
    task automatic issue(input logic [2:0] op, input logic [DW-1:0] data, input logic [4:0] len);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_data = data; cmd_len = len;
        @(posedge clk);
        #1;
        cmd_valid = 1'b0;
    endtask

    task automatic drain();
        wait (sb_q.size() == 0);
        @(posedge clk);
    endtask

    task automatic do_setup();
        issue(3'd0, '0, 5'd0);
        push_step(m_cs, 1'b0, 1'b0, "R3");
        push_step(1'b1, m_sk, m_di, "R3");
        push_finish("R8");
        drain();
    endtask

    task automatic do_standby(input bit poke);
        issue(3'd1, '0, 5'd0);
        push_step(1'b0, 1'b0, m_di, "R4");
        push_step(m_cs, 1'b1, m_di, "R4");
        push_step(1'b1, m_sk, m_di, "R4");
        push_step(m_cs, 1'b0, m_di, "R4");
        push_finish("R8");
        if (poke) begin
            // R9: requests during the run must leave it untouched
            @(negedge clk); @(negedge clk);
            cmd_valid = 1'b1; cmd_op = 3'd2;
            @(negedge clk);
            cmd_op = 3'd3; cmd_len = 5'd4; cmd_data = 16'hF;
            @(negedge clk);
            cmd_valid = 1'b0;
        end
        drain();
    endtask

    task automatic do_cleanup();
        issue(3'd2, '0, 5'd0);
        push_step(1'b0, m_sk, 1'b0, "R5");
        push_step(m_cs, 1'b1, m_di, "R5");
        push_step(m_cs, 1'b0, m_di, "R5");
        push_finish("R8");
        drain();
    endtask

    task automatic do_shout(input logic [DW-1:0] data, input int len);
        issue(3'd3, data, 5'(len));
        for (int b = len - 1; b >= 0; b--) begin
            push_step(m_cs, m_sk, data[b], "R6");
            push_step(m_cs, 1'b1, m_di, "R6");
            push_step(m_cs, 1'b0, m_di, "R6");
        end
        push_step(m_cs, m_sk, 1'b0, "R6");
        push_finish("R8");
        drain();
    endtask

    task automatic do_shin(input logic [DW-1:0] src, input int len);
        logic [DW-1:0] want;
        rx_src = src; rx_idx = len - 1; rx_mode = 1'b1;
        issue(3'd4, 16'hFFFF, 5'(len));
        for (int b = 0; b < len; b++) begin
            push_step(m_cs, 1'b1, m_di, "R7");
            push_step(m_cs, 1'b0, m_di, "R7");
        end
        push_finish("R8");
        drain();
        rx_mode = 1'b0;
        want = (len == DW) ? src : (src & ((16'h1 << len) - 16'h1));
        n_cmp++;
        if (rx_data !== want) begin
            n_bad++;
            $display("FAIL R7: rx_data got %h expected %h (len %0d)", rx_data, want, len);
        end
    endtask

    task automatic do_ignored(input logic [2:0] op, input logic [4:0] len);
        issue(op, 16'hFFFF, len);
        push_idle(2 * PHASE + 2, "R10");
        drain();
    endtask

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish, got hung expected done");
            report();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1: quiet reset state, and R11 idle clock low
        @(negedge clk);
        n_cmp++;
        if ({ee_cs, ee_sk, ee_di, busy, done, rx_data} !== '0) begin
            n_bad++;
            $display("FAIL R1: outputs got %b/%h expected all zero",
                     {ee_cs, ee_sk, ee_di, busy, done}, rx_data);
        end
        push_idle(3, "R11");
        drain();

        do_setup();                    // R3
        do_shout(16'hB5C3, 9);         // R6: bits 8..0 = 1_1100_0011
        do_shout(16'h8001, 16);        // R6: full width
        do_shout(16'h0001, 1);         // R6: single bit
        do_shin(16'h00A5, 8);          // R7
        do_shin(16'h3C96, 16);         // R7 full width
        do_shin(16'h0001, 1);          // R7 single bit
        do_cleanup();                  // R5
        do_standby(1'b1);              // R4 with R9 pokes
        do_ignored(3'd6, 5'd4);        // R10 bad opcode
        do_ignored(3'd7, 5'd4);        // R10 bad opcode
        do_ignored(3'd3, 5'd0);        // R10 zero length
        do_ignored(3'd4, 5'd17);       // R10 length too large
        do_setup();                    // R2 timing again after idle
        do_shout(16'h0FF0, 12);
        do_cleanup();
        push_idle(4, "R11");
        drain();

        finished = 1'b1;
        report();
    end
endmodule